// File: doc/BRIEF.md
# Wave Table Playback Channel

This channel holds thirty-two 4-bit samples, packed two to a byte in a sixteen-byte wave memory, and steps through them at a rate set by an 11-bit period value. A trigger strobe starts playback. The channel first replays whatever sample it last latched, then walks the table starting at index 1. Index 0 is reached last in each lap. A 2-bit level code scales the outgoing sample with a digital right shift. The code does not affect which sample is latched.

The wave memory is loaded through a valid/ready write port. `wr_ready` is tied high, so the port never applies back-pressure and every beat with `wr_valid` high is accepted on that clock edge. The audio output is a plain 4-bit level. A one-cycle strobe marks each newly fetched sample. Dropping the DAC enable stops the channel. The latched sample survives, so the next trigger replays it.

Top module: `wavetable_channel`

## Requirements
- R1: After reset, `sample_out` is 0, `active` is 0 and `fetch_stb` is 0.
- R2: `wr_ready` is always 1. A beat with `wr_valid` high stores `wr_data` at byte `wr_addr`. Bits [7:4] become sample index 2*addr and bits [3:0] become sample index 2*addr+1.
- R3: A `trigger` sampled with `dac_en` high sets `active` on that edge. The previously latched sample then stays on the output for exactly P = 2048 - `period` cycles.
- R4: If no sample has been latched since reset, the held sample replayed after a trigger is 0.
- R5: After the held sample, indices 1, 2, ..., 31, 0, 1, ... play in turn, each for P cycles.
- R6: `fetch_stb` is high for exactly the one cycle in which a newly fetched sample first appears, and at no other time.
- R7: The output for a latched sample s depends on `level`. Code 0 gives 0, code 1 gives s, code 2 gives s>>1 and code 3 gives s>>2. The code takes effect without delay.
- R8: Changing `level` during playback does not alter the sequence of latched samples.
- R9: With `dac_en` low at a clock edge, `active` is 0 after that edge, no sample is latched, and a `trigger` is ignored.
- R10: While `active` is 0, `sample_out` is 0. A later trigger replays the sample that was latched before deactivation.
- R11: A trigger while playing restarts the timer. The sample showing before the trigger edge is held for a full P cycles, and playback then resumes at index 1. Trigger takes priority over a coinciding timer expiry.
- R12: `period` 2047 fetches a new sample every cycle, and `period` 0 holds each sample for 2048 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Wave memory write beat valid |
| wr_ready | output | 1 | Write beat accepted (always 1) |
| wr_addr | input | 4 | Byte address in wave memory |
| wr_data | input | 8 | Byte holding two samples, earlier one in high nibble |
| period | input | 11 | Period value; sample time P = 2048 - period |
| trigger | input | 1 | Start or restart playback |
| dac_en | input | 1 | Channel enable; low deactivates |
| level | input | 2 | Output level code |
| sample_out | output | 4 | Shifted digital sample |
| active | output | 1 | Channel is playing |
| fetch_stb | output | 1 | One-cycle pulse on each newly latched sample |

## Verification
Assertions check four things on every cycle: the timer never sits at zero while the channel plays, the position moves only on a timer expiry or a trigger, a trigger leaves the latched sample untouched, and a disabled or inactive channel outputs 0. Only the bench's scenarios can show that the audible order is the held sample, then index 1 through 31, then index 0. The same holds for the nibble order within each byte, the exact P-cycle sample length at both period extremes, the level shift values, and the replay of a sample latched before a deactivation or retrigger.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int SAMPLE_W    = 4;
  localparam int NUM_SAMPLES = 32;
  localparam int PERIOD_W    = 11;

  typedef enum logic [1:0] {
    LVL_MUTE    = 2'd0,
    LVL_FULL    = 2'd1,
    LVL_HALF    = 2'd2,
    LVL_QUARTER = 2'd3
  } level_e;
endpackage

// File: rtl/wt_ram.sv
module wt_ram #(
  parameter int SAMPLE_W    = 4,
  parameter int NUM_SAMPLES = 32,
  localparam int BYTE_W     = 2 * SAMPLE_W,
  localparam int NUM_BYTES  = NUM_SAMPLES / 2,
  localparam int ADDR_W     = $clog2(NUM_BYTES),
  localparam int IDX_W      = $clog2(NUM_SAMPLES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   waddr,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic [IDX_W-1:0]    ridx,
  output logic [SAMPLE_W-1:0] rnib
);
  logic [BYTE_W-1:0] mem [NUM_BYTES];
  logic [BYTE_W-1:0] rbyte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BYTES; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // even index -> upper nibble, odd index -> lower nibble
  assign rbyte = mem[ridx[IDX_W-1:1]];
  assign rnib  = ridx[0] ? rbyte[SAMPLE_W-1:0] : rbyte[BYTE_W-1:SAMPLE_W];
endmodule

// File: rtl/wt_timer.sv
module wt_timer #(
  parameter int PERIOD_W  = 11,
  localparam int TIMER_W  = PERIOD_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  output logic                expire
);
  localparam logic [TIMER_W-1:0] FULL = TIMER_W'(1) << PERIOD_W;

  logic [TIMER_W-1:0] cnt;
  logic [TIMER_W-1:0] reload;

  assign reload = FULL - {1'b0, period};
  assign expire = run && !load && (cnt == TIMER_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (load || expire)   cnt <= reload;
    else if (run)              cnt <= cnt - TIMER_W'(1);
  end

  // R12: a running timer is never stuck at zero, so any period yields expiries
  assert_timer_live_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |-> (cnt != '0));
endmodule

// File: rtl/wt_level.sv
module wt_level #(
  parameter int SAMPLE_W = 4
) (
  input  logic                active,
  input  logic [1:0]          code,
  input  logic [SAMPLE_W-1:0] held,
  output logic [SAMPLE_W-1:0] out
);
  import wt_pkg::*;

  always_comb begin
    out = '0;
    if (active) begin
      unique case (level_e'(code))
        LVL_MUTE:    out = '0;
        LVL_FULL:    out = held;
        LVL_HALF:    out = held >> 1;
        LVL_QUARTER: out = held >> 2;
        default:     out = '0;
      endcase
    end
  end
endmodule

// File: rtl/wavetable_channel.sv
module wavetable_channel #(
  parameter int SAMPLE_W    = wt_pkg::SAMPLE_W,
  parameter int NUM_SAMPLES = wt_pkg::NUM_SAMPLES,
  parameter int PERIOD_W    = wt_pkg::PERIOD_W,
  localparam int BYTE_W     = 2 * SAMPLE_W,
  localparam int ADDR_W     = $clog2(NUM_SAMPLES / 2),
  localparam int IDX_W      = $clog2(NUM_SAMPLES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [PERIOD_W-1:0] period,
  input  logic                trigger,
  input  logic                dac_en,
  input  logic [1:0]          level,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic                active,
  output logic                fetch_stb
);
  logic [IDX_W-1:0]    idx;
  logic [IDX_W-1:0]    idx_next;
  logic [SAMPLE_W-1:0] held;
  logic [SAMPLE_W-1:0] fetched;
  logic                start;
  logic                expire;

  assign wr_ready = 1'b1;
  assign start    = trigger && dac_en;
  assign idx_next = idx + IDX_W'(1);

  wt_ram #(.SAMPLE_W(SAMPLE_W), .NUM_SAMPLES(NUM_SAMPLES)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(wr_valid && wr_ready),
    .waddr(wr_addr), .wdata(wr_data), .ridx(idx_next), .rnib(fetched)
  );

  wt_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(start), .run(active && dac_en),
    .period(period), .expire(expire)
  );

  wt_level #(.SAMPLE_W(SAMPLE_W)) u_level (
    .active(active), .code(level), .held(held), .out(sample_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      idx       <= '0;
      held      <= '0;
      fetch_stb <= 1'b0;
    end else begin
      fetch_stb <= 1'b0;
      if (!dac_en) begin
        active <= 1'b0;
      end else if (trigger) begin
        active <= 1'b1;
        idx    <= '0;
      end else if (active && expire) begin
        idx       <= idx_next;
        held      <= fetched;
        fetch_stb <= 1'b1;
      end
    end
  end

  assert_dac_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_en |=> !active);
  assert_trigger_keeps_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && idx == '0 && held == $past(held)));
  assert_idle_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (sample_out == '0));
  assert_index_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !expire) |=> $stable(idx));
  assert_fetch_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |-> (active && idx == $past(idx) + IDX_W'(1)));
endmodule

// File: tb/wavetable_channel_test.sv
module wavetable_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [10:0] period = '0;
  logic        trigger = 1'b0;
  logic        dac_en = 1'b0;
  logic [1:0]  level = 2'd1;
  logic [3:0]  sample_out;
  logic        active;
  logic        fetch_stb;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  int exp_ram [32];
  int held0 = 0;

  wavetable_channel uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .period(period), .trigger(trigger),
    .dac_en(dac_en), .level(level), .sample_out(sample_out), .active(active),
    .fetch_stb(fetch_stb)
  );

  always #2.5 clk = ~clk;

  function automatic int shf(int s, int code);
    if (code == 0) return 0;
    return s >> (code - 1);
  endfunction

  // raw sample expected in cycle c (1-based) after a trigger edge
  function automatic int raw_at(int c, int p, int h);
    int k = (c - 1) / p;
    if (k == 0) return h;
    return exp_ram[k % 32];
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    wr_valid = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    check("R2 ready", int'(wr_ready), 1);
    @(negedge clk);
    wr_valid = 1'b0;
    exp_ram[2*a]   = (d >> 4) & 15;
    exp_ram[2*a+1] = d & 15;
  endtask

  // called at a negedge; leaves at the negedge of cycle n, channel still playing
  task automatic run(int per, int n, bit rand_lvl);
    int p = 2048 - per;
    period = 11'(per); dac_en = 1'b1; trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    for (int c = 1; c <= n; c++) begin
      int r = raw_at(c, p, held0);
      check("R3/R5/R7 sample", int'(sample_out), shf(r, int'(level)));
      check("R6 fetch", int'(fetch_stb), (c > 1 && (c - 1) % p == 0) ? 1 : 0);
      check("R3 active", int'(active), 1);
      if (c < n) begin
        if (rand_lvl) level = 2'($urandom % 4);
        @(negedge clk);
      end
    end
    held0 = raw_at(n, p, held0);
  endtask

  task automatic stop();
    dac_en = 1'b0;
    @(negedge clk);
    check("R9 inactive", int'(active), 0);
    check("R10 silent", int'(sample_out), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) exp_ram[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out", int'(sample_out), 0);
    check("R1 active", int'(active), 0);
    check("R1 fetch", int'(fetch_stb), 0);

    // directed fill: distinct nibbles show ordering (R2, R5)
    for (int a = 0; a < 16; a++) wr(a, ((2*a) % 16) * 16 + ((2*a + 1) % 16));
    exp_ram[0] = 0;
    wr(0, 8'h9C);

    // R4: first play replays 0, then index 1 onward
    level = 2'd1;
    run(2045, 3 * 34, 1'b0);
    stop();

    // R9: trigger ignored while disabled
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    check("R9 trigger ignored", int'(active), 0);
    check("R9 silent", int'(sample_out), 0);

    // R10: replay of sample latched before deactivation
    run(2044, 4 * 33, 1'b0);
    // R11: retrigger while playing, exactly on an expiry boundary
    run(2044, 4 * 5, 1'b0);
    run(2044, 4 * 3 + 2, 1'b0);
    stop();

    // R12: fastest rate
    run(2047, 70, 1'b0);
    stop();

    // R7/R8: random level changes mid-play
    for (int it = 0; it < 8; it++) begin
      for (int a = 0; a < 16; a++) wr(a, int'($urandom % 256));
      level = 2'($urandom % 4);
      run(2047 - int'($urandom % 6), 200, 1'b1);
      stop();
    end

    // R12: slowest rate, period 0 -> 2048 cycles per sample
    level = 2'd1;
    run(0, 2 * 2048 + 2, 1'b0);
    stop();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule